// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Vote Mode

This block controls a PLL through a 32-bit mode register. Software drives it with a full-word write port and with single-cycle enable and disable strobes. Three register bits drive the PLL directly: an output gate, a bypass release (active high) and an active-low PLL reset. When enable is requested, the block releases these bits in a fixed order. Bypass is released first. Reset is released a set number of microseconds later. The output gate opens after a further lock wait. Timing comes from a microsecond tick, which a parameterised divider of the system clock produces.

A second owner, a hardware voter, can take the PLL. A three-step setup sequence clears the voter's reset, loads its bias and lock counts, and then sets vote-mode enable. Once vote-mode enable is set, software enable and disable strobes have no effect.

A separate vote requester starts on a strobe. It samples a PLL lock status input once per microsecond and pulses either a success or a timeout result. While any timed or ordered sequence runs, a busy output stays high.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the mode register reads 32'h0020_0000: only vote-mode reset (bit 21) is set. All three PLL controls are low, and busy, vote_ok and vote_timeout are low.
- R2: The mode register fields are: output gate at bit 0, bypass release at bit 1, active-low reset at bit 2, lock count at bits 13:8, bias count at bits 19:14, vote-mode enable at bit 20 and vote-mode reset at bit 21. A write loads these bits on the next edge, and all other bits read zero. A write also cancels any sequence in progress.
- R3: An accepted enable sets the bypass release at the clock edge that samples the request. The reset is released exactly BYPASS_GAP_US*TICK_DIV cycles after that edge.
- R4: The output gate is set exactly LOCK_WAIT_US*TICK_DIV cycles after the reset release. It never rises by sequence unless reset and bypass are already released.
- R5: busy is high from the edge that starts an enable, vote-setup or vote-request sequence until the edge that ends it.
- R6: An enable while all three control bits are already set changes nothing and starts no sequence.
- R7: A disable clears all three control bits at one clock edge.
- R8: A disable during an enable sequence aborts it. The three controls are zero after the next edge, busy drops, and the output gate stays low afterward.
- R9: A vote-setup request applies its steps on three consecutive edges. First it clears vote-mode reset. Next it sets bias count to 1 and lock count to 0. Last it sets vote-mode enable.
- R10: While vote-mode enable is set, enable and disable strobes leave the three control bits unchanged.
- R11: After a vote request, the lock input is sampled every TICK_DIV cycles, first at TICK_DIV cycles after the request edge. vote_ok pulses for one cycle at the edge of the first sample that sees lock high.
- R12: If none of VOTE_SAMPLES samples sees lock, vote_timeout pulses for one cycle, VOTE_SAMPLES*TICK_DIV cycles after the request edge. vote_ok and vote_timeout are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Write strobe for the mode register |
| mode_wr_data | input | 32 | Write data for the mode register |
| mode_rd_data | output | 32 | Current mode register value |
| sw_en_req | input | 1 | Software enable strobe |
| sw_dis_req | input | 1 | Software disable strobe |
| vote_setup_req | input | 1 | Starts the vote-mode setup steps |
| vote_req | input | 1 | Starts a vote wait on the lock status |
| pll_locked | input | 1 | PLL lock status |
| pll_out_en | output | 1 | PLL output gate |
| pll_bypass_n | output | 1 | PLL bypass release, active high |
| pll_reset_n | output | 1 | Active-low PLL reset |
| busy | output | 1 | A sequence is in progress |
| vote_ok | output | 1 | One-cycle pulse: lock seen |
| vote_timeout | output | 1 | One-cycle pulse: lock never seen |

## Verification
Each result falls a fixed number of edges after the strobe edge E0. Bypass release and the first vote-setup step are visible right after E0. Reset release comes at E0+10·TICK_DIV and the output gate at E0+60·TICK_DIV. The vote-setup steps land at E0+1 and E0+2. A vote result appears at E0+k·TICK_DIV for sample k.

The bench drives every strobe and samples every output on falling edges. It counts the rising edges from E0 to each result. It checks one cycle before the expected edge and again just after it, so both an early and a late transition are reported.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef struct packed {
        logic [9:0] rsv_hi;
        logic       vote_rst;
        logic       vote_en;
        logic [5:0] bias_cnt;
        logic [5:0] lock_cnt;
        logic [4:0] rsv_lo;
        logic       rst_n;
        logic       byp_n;
        logic       out_en;
    } mode_reg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BYP_WAIT,
        S_LOCK_WAIT,
        S_VOTE_CNT,
        S_VOTE_EN
    } seq_state_t;

    localparam logic [31:0] MODE_MASK  = 32'h003F_FF07;
    localparam logic [31:0] MODE_RESET = 32'h0020_0000;

    function automatic mode_reg_t mode_clean(input logic [31:0] raw);
        return mode_reg_t'(raw & MODE_MASK);
    endfunction

endpackage

// File: rtl/pll_us_tick.sv
module pll_us_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R3
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter int BYP_US  = 10,
    parameter int LOCK_US = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        en_req,
    input  logic        dis_req,
    input  logic        vsetup_req,
    output mode_reg_t   mode,
    output logic        busy,
    output logic        tick_clr
);
    localparam int MAXW = (BYP_US > LOCK_US) ? BYP_US : LOCK_US;
    localparam int UW   = $clog2(MAXW + 1);

    seq_state_t    st;
    logic [UW-1:0] us_cnt;
    logic          ctrl_all;

    assign ctrl_all = mode.out_en & mode.byp_n & mode.rst_n;
    assign busy     = (st != S_IDLE);
    assign tick_clr = (st == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= mode_reg_t'(MODE_RESET);
            st     <= S_IDLE;
            us_cnt <= '0;
        end else if (wr_en) begin
            mode   <= mode_clean(wr_data);
            st     <= S_IDLE;
            us_cnt <= '0;
        end else if (dis_req && !mode.vote_en) begin
            mode.out_en <= 1'b0;
            mode.byp_n  <= 1'b0;
            mode.rst_n  <= 1'b0;
            st          <= S_IDLE;
            us_cnt      <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (en_req && !ctrl_all && !mode.vote_en) begin
                        mode.byp_n <= 1'b1;
                        st         <= S_BYP_WAIT;
                        us_cnt     <= '0;
                    end else if (vsetup_req) begin
                        mode.vote_rst <= 1'b0;
                        st            <= S_VOTE_CNT;
                    end
                end
                S_BYP_WAIT: begin
                    if (tick) begin
                        if (us_cnt == UW'(BYP_US - 1)) begin
                            mode.rst_n <= 1'b1;
                            st         <= S_LOCK_WAIT;
                            us_cnt     <= '0;
                        end else begin
                            us_cnt <= us_cnt + 1'b1;
                        end
                    end
                end
                S_LOCK_WAIT: begin
                    if (tick) begin
                        if (us_cnt == UW'(LOCK_US - 1)) begin
                            mode.out_en <= 1'b1;
                            st          <= S_IDLE;
                            us_cnt      <= '0;
                        end else begin
                            us_cnt <= us_cnt + 1'b1;
                        end
                    end
                end
                S_VOTE_CNT: begin
                    mode.bias_cnt <= 6'd1;
                    mode.lock_cnt <= 6'd0;
                    st            <= S_VOTE_EN;
                end
                S_VOTE_EN: begin
                    mode.vote_en <= 1'b1;
                    st           <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R4
    out_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode.out_en) |-> $past(wr_en) || ($past(mode.rst_n) && $past(mode.byp_n)));

    // R7
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (dis_req && !wr_en && !mode.vote_en) |=> !mode.out_en && !mode.byp_n && !mode.rst_n);

    // R10
    vote_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.vote_en && !wr_en) |=> $stable({mode.out_en, mode.byp_n, mode.rst_n}));

    // R9
    vote_en_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode.vote_en) |-> $past(wr_en) ||
            ($past(mode.bias_cnt) == 6'd1 && $past(mode.lock_cnt) == 6'd0 && !$past(mode.vote_rst)));
endmodule

// File: rtl/pll_vote_wait.sv
module pll_vote_wait #(
    parameter int SAMPLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic lock,
    output logic active,
    output logic ok,
    output logic tout,
    output logic tick_clr
);
    localparam int SW = $clog2(SAMPLES + 1);

    logic [SW-1:0] smp_cnt;

    assign tick_clr = !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            ok      <= 1'b0;
            tout    <= 1'b0;
            smp_cnt <= '0;
        end else begin
            ok   <= 1'b0;
            tout <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    smp_cnt <= '0;
                end
            end else if (tick) begin
                if (lock) begin
                    ok     <= 1'b1;
                    active <= 1'b0;
                end else if (smp_cnt == SW'(SAMPLES - 1)) begin
                    tout   <= 1'b1;
                    active <= 1'b0;
                end else begin
                    smp_cnt <= smp_cnt + 1'b1;
                end
            end
        end
    end

    // R12
    vote_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ok, tout}));

    // R11
    vote_ok_src_chk: assert property (@(posedge clk) disable iff (rst)
        ok |-> $past(active) && $past(lock));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int TICK_DIV      = 125,
    parameter int BYPASS_GAP_US = 10,
    parameter int LOCK_WAIT_US  = 50,
    parameter int VOTE_SAMPLES  = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_wr_en,
    input  logic [31:0] mode_wr_data,
    output logic [31:0] mode_rd_data,
    input  logic        sw_en_req,
    input  logic        sw_dis_req,
    input  logic        vote_setup_req,
    input  logic        vote_req,
    input  logic        pll_locked,
    output logic        pll_out_en,
    output logic        pll_bypass_n,
    output logic        pll_reset_n,
    output logic        busy,
    output logic        vote_ok,
    output logic        vote_timeout
);
    mode_reg_t mode;
    logic      seq_tick, seq_clr, seq_busy;
    logic      vote_tick, vote_clr, vote_active;

    pll_us_tick #(.DIV(TICK_DIV)) i_seq_tick (
        .clk (clk), .rst (rst), .clr (seq_clr), .tick (seq_tick)
    );

    pll_us_tick #(.DIV(TICK_DIV)) i_vote_tick (
        .clk (clk), .rst (rst), .clr (vote_clr), .tick (vote_tick)
    );

    pll_pwr_seq #(.BYP_US(BYPASS_GAP_US), .LOCK_US(LOCK_WAIT_US)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (seq_tick),
        .wr_en      (mode_wr_en),
        .wr_data    (mode_wr_data),
        .en_req     (sw_en_req),
        .dis_req    (sw_dis_req),
        .vsetup_req (vote_setup_req),
        .mode       (mode),
        .busy       (seq_busy),
        .tick_clr   (seq_clr)
    );

    pll_vote_wait #(.SAMPLES(VOTE_SAMPLES)) i_vote (
        .clk      (clk),
        .rst      (rst),
        .tick     (vote_tick),
        .start    (vote_req),
        .lock     (pll_locked),
        .active   (vote_active),
        .ok       (vote_ok),
        .tout     (vote_timeout),
        .tick_clr (vote_clr)
    );

    assign mode_rd_data = mode;
    assign pll_out_en   = mode.out_en;
    assign pll_bypass_n = mode.byp_n;
    assign pll_reset_n  = mode.rst_n;
    assign busy         = seq_busy | vote_active;
endmodule

// File: tb/test_pll_seq_ctrl.sv
module test_pll_seq_ctrl;
    localparam int D = 125;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr_en = 1'b0;
    logic [31:0] mode_wr_data = '0;
    logic [31:0] mode_rd_data;
    logic        sw_en_req = 1'b0, sw_dis_req = 1'b0;
    logic        vote_setup_req = 1'b0, vote_req = 1'b0, pll_locked = 1'b0;
    logic        pll_out_en, pll_bypass_n, pll_reset_n, busy, vote_ok, vote_timeout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pll_seq_ctrl #(.TICK_DIV(D)) i_pll_seq_ctrl (
        .clk (clk), .rst (rst),
        .mode_wr_en (mode_wr_en), .mode_wr_data (mode_wr_data), .mode_rd_data (mode_rd_data),
        .sw_en_req (sw_en_req), .sw_dis_req (sw_dis_req),
        .vote_setup_req (vote_setup_req), .vote_req (vote_req), .pll_locked (pll_locked),
        .pll_out_en (pll_out_en), .pll_bypass_n (pll_bypass_n), .pll_reset_n (pll_reset_n),
        .busy (busy), .vote_ok (vote_ok), .vote_timeout (vote_timeout)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic adv(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [2:0] ctrl();
        return {pll_reset_n, pll_bypass_n, pll_out_en};
    endfunction

    task automatic do_en();  @(negedge clk); sw_en_req = 1; @(negedge clk); sw_en_req = 0; endtask
    task automatic do_dis(); @(negedge clk); sw_dis_req = 1; @(negedge clk); sw_dis_req = 0; endtask
    task automatic do_wr(logic [31:0] d);
        @(negedge clk); mode_wr_en = 1; mode_wr_data = d;
        @(negedge clk); mode_wr_en = 0;
    endtask

    task automatic t_reset();
        check("R1 mode", mode_rd_data, 32'h0020_0000);
        check("R1 ctrl", ctrl(), 3'b000);
        check("R1 busy/vote", {busy, vote_ok, vote_timeout}, 3'b000);
    endtask

    task automatic t_enable();
        do_en();
        check("R3 bypass first", ctrl(), 3'b010);
        check("R5 busy in seq", busy, 1'b1);
        adv(10*D - 1);
        check("R3 reset held", pll_reset_n, 1'b0);
        adv(1);
        check("R3 reset released", ctrl(), 3'b110);
        adv(50*D - 1);
        check("R4 out held", pll_out_en, 1'b0);
        adv(1);
        check("R4 out on", mode_rd_data[2:0], 3'b111);
        check("R5 busy end", busy, 1'b0);
    endtask

    task automatic t_already_on();
        do_en();
        check("R6 no seq", busy, 1'b0);
        adv(D + 1);
        check("R6 ctrl kept", ctrl(), 3'b111);
    endtask

    task automatic t_disable();
        do_dis();
        check("R7 one update", mode_rd_data[2:0], 3'b000);
    endtask

    task automatic t_abort();
        do_en();
        adv(10*D + 5);
        check("R8 mid seq", ctrl(), 3'b110);
        do_dis();
        check("R8 aborted", {busy, ctrl()}, 4'b0000);
        adv(50*D + 10);
        check("R8 stays off", pll_out_en, 1'b0);
    endtask

    task automatic t_write();
        do_en();
        adv(3);
        do_wr(32'h0);
        check("R2 write cancels", {busy, ctrl()}, 4'b0000);
        adv(11*D);
        check("R2 no late release", pll_reset_n, 1'b0);
        do_wr(32'hFFEF_FFF8);
        check("R2 field mask", mode_rd_data, 32'h002F_FF00);
    endtask

    task automatic t_vote_setup();
        @(negedge clk); vote_setup_req = 1; @(negedge clk); vote_setup_req = 0;
        check("R9 step1", mode_rd_data, 32'h000F_FF00);
        check("R5 busy setup", busy, 1'b1);
        adv(1);
        check("R9 step2", mode_rd_data, 32'h0000_4000);
        adv(1);
        check("R9 step3", mode_rd_data, 32'h0010_4000);
        check("R5 setup done", busy, 1'b0);
    endtask

    task automatic t_vote_noop();
        do_en();
        check("R10 enable ignored", {busy, ctrl()}, 4'b0000);
        adv(10*D + 2);
        check("R10 still off", ctrl(), 3'b000);
        do_wr(32'h0010_4007);
        check("R10 written", ctrl(), 3'b111);
        do_dis();
        check("R10 disable ignored", ctrl(), 3'b111);
    endtask

    task automatic t_vote_ok();
        pll_locked = 0;
        @(negedge clk); vote_req = 1; @(negedge clk); vote_req = 0;
        check("R5 busy vote", busy, 1'b1);
        adv(3*D + 10);
        pll_locked = 1;
        adv(D - 11);
        check("R11 before sample", vote_ok, 1'b0);
        adv(1);
        check("R11 ok pulse", {vote_ok, vote_timeout}, 2'b10);
        adv(1);
        check("R11 pulse ends", {vote_ok, busy}, 2'b00);
        pll_locked = 0;
    endtask

    task automatic t_vote_timeout();
        @(negedge clk); vote_req = 1; @(negedge clk); vote_req = 0;
        adv(200*D - 1);
        check("R12 before timeout", {vote_timeout, busy}, 2'b01);
        adv(1);
        check("R12 timeout pulse", {vote_ok, vote_timeout}, 2'b01);
        adv(1);
        check("R12 idle after", {vote_timeout, busy}, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_enable();
        t_already_on();
        t_disable();
        t_abort();
        t_write();
        t_vote_setup();
        t_vote_noop();
        t_vote_ok();
        t_vote_timeout();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule